// File: doc/BRIEF.md
# Descriptor-Chained Source DMA Walker

This block is the source side of a DMA engine that feeds 32-bit words to a hashing core. It runs in one of two modes. In direct mode it reads one contiguous region, given by a start address and a byte size. In list mode it follows a chain of four-word descriptors in memory. Each descriptor gives a data address, a byte length, the address of the next descriptor, and a flags word. The data words leave on a valid/ready stream. The last word of the whole transfer is marked.

Software programs the address, size and pointer registers through a small write port. It then writes the mode register with the run bit set. Completion and errors are recorded as sticky bits in an interrupt status register. Software clears a bit by writing 1 to it. An enable register and a global unmask bit decide which status bits raise the interrupt line. The done bit means that every source word has been handed to the core. The core may still be working on the last of that data.

Top module: `dma_src_walker`

## Requirements
- R1: Direct mode streams ceil(size/4) words, read from ascending word addresses starting at the source-address register. A size of 0 streams nothing and still completes.
- R2: List mode takes the first descriptor address from the descriptor-pointer register. It reads the descriptor words at byte offsets 0, 4, 8 and 12, which hold data address, byte length, next-descriptor address and flags.
- R3: A descriptor whose flags bit 31 is 1 is the last one: the walk ends once its data has been streamed. Otherwise the walk continues at the descriptor's next-descriptor address.
- R4: A descriptor with length 0 issues no data reads and streams no words.
- R5: Register map, selected by the 3-bit write address: 0 = mode, 1 = source address, 2 = source size, 3 = descriptor pointer, 4 = interrupt status, 5 = interrupt enable, 6 = unmask. A mode write starts a run only if bit 31 is 1. Bit 25 selects list mode. A mode write while busy is ignored.
- R6: Every memory request carries mode bits 30:28 on `mem_req_attr`.
- R7: Status bit 0 is set once the final word has been accepted downstream, and `out_last` is high only with that final word.
- R8: An error response to a data read aborts the run and sets status bit 4, and bit 0 stays 0.
- R9: An error response to a descriptor read aborts the run and sets status bit 3.
- R10: Writing 1s to the status register clears those bits. `irq` is high exactly when some status bit has its enable bit set and unmask bit 0 is 1.
- R11: At most one read is outstanding. A pending request holds its address until accepted, and no read is issued while a word waits on the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 32 | Read byte address |
| mem_req_attr | output | 3 | Snoop attributes from the mode register |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 32 | Read response data |
| mem_rsp_err | input | 1 | Read response error |
| out_valid | output | 1 | Stream word valid |
| out_ready | input | 1 | Stream word accepted |
| out_data | output | 32 | Stream word |
| out_last | output | 1 | Final word of the transfer |
| busy | output | 1 | A run is in progress |
| irq_status | output | STAT_W | Sticky interrupt status |
| irq | output | 1 | Interrupt line |

## Verification
The bound checker tests the handshake rules on every cycle: a stalled request or stalled stream word keeps its value, and no read is issued while a word is held. It also checks that an error abort returns the engine to idle on the next cycle, that a mode write without the run bit never starts a run, and that the interrupt line is high only when status, enable and unmask allow it. Only the bench scenarios can show the word order and counts. These include how the walk treats zero-length and terminating descriptors in a real chain, the error bit that each kind of failed read leaves behind, and that a mode write during a run has no effect.

// File: rtl/dma_walk_pkg.sv
package dma_walk_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    W_IDLE, W_DREQ, W_DWAIT, W_CHECK, W_RREQ, W_RWAIT, W_OUT, W_FINISH
  } walk_state_e;

  localparam logic [2:0] REG_MODE      = 3'd0;
  localparam logic [2:0] REG_SRC_ADDR  = 3'd1;
  localparam logic [2:0] REG_SRC_SIZE  = 3'd2;
  localparam logic [2:0] REG_DESC_PTR  = 3'd3;
  localparam logic [2:0] REG_IRQ_STAT  = 3'd4;
  localparam logic [2:0] REG_IRQ_EN    = 3'd5;
  localparam logic [2:0] REG_IRQ_UNMSK = 3'd6;

  localparam int MODE_RUN_BIT  = 31;
  localparam int MODE_LIST_BIT = 25;
  localparam int MODE_ATTR_LO  = 28;
  localparam int FLAG_LAST_BIT = 31;

  localparam int ST_DONE     = 0;
  localparam int ST_DESC_ERR = 3;
  localparam int ST_RD_ERR   = 4;

  // Byte count rounded up to whole 32-bit words.
  function automatic logic [WORD_W-1:0] bytes_to_words(input logic [WORD_W-1:0] nbytes);
    return (nbytes >> 2) + {{(WORD_W-1){1'b0}}, |nbytes[1:0]};
  endfunction

  // Byte address of word idx inside a descriptor.
  function automatic logic [WORD_W-1:0] desc_word_addr(input logic [WORD_W-1:0] base,
                                                       input logic [1:0] idx);
    return base + {{(WORD_W-4){1'b0}}, idx, 2'b00};
  endfunction
endpackage

// File: rtl/dma_walk_regs.sv
module dma_walk_regs
  import dma_walk_pkg::*;
#(
  parameter int STAT_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              busy,
  input  logic              evt_done,
  input  logic              evt_desc_err,
  input  logic              evt_rd_err,
  output logic              start,
  output logic              list_sel,
  output logic [WORD_W-1:0] src_addr,
  output logic [WORD_W-1:0] src_size,
  output logic [WORD_W-1:0] desc_ptr,
  output logic [2:0]        attr,
  output logic [STAT_W-1:0] stat,
  output logic [STAT_W-1:0] irq_en,
  output logic              irq_unmask,
  output logic              irq
);
  logic [WORD_W-1:0] mode_q;
  logic [STAT_W-1:0] stat_clr, stat_set;
  logic              mode_wr;

  assign mode_wr  = cfg_we && (cfg_addr == REG_MODE) && !busy;
  assign start    = mode_wr && cfg_wdata[MODE_RUN_BIT];
  assign list_sel = cfg_wdata[MODE_LIST_BIT];
  assign attr     = mode_q[MODE_ATTR_LO +: 3];

  always_comb begin
    stat_clr = '0;
    if (cfg_we && cfg_addr == REG_IRQ_STAT) stat_clr = cfg_wdata[STAT_W-1:0];
    stat_set = '0;
    stat_set[ST_DONE]     = evt_done;
    stat_set[ST_DESC_ERR] = evt_desc_err;
    stat_set[ST_RD_ERR]   = evt_rd_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= '0;
      src_addr   <= '0;
      src_size   <= '0;
      desc_ptr   <= '0;
      stat       <= '0;
      irq_en     <= '0;
      irq_unmask <= 1'b0;
    end else begin
      if (mode_wr) mode_q <= cfg_wdata;
      if (cfg_we && cfg_addr == REG_SRC_ADDR)  src_addr   <= cfg_wdata;
      if (cfg_we && cfg_addr == REG_SRC_SIZE)  src_size   <= cfg_wdata;
      if (cfg_we && cfg_addr == REG_DESC_PTR)  desc_ptr   <= cfg_wdata;
      if (cfg_we && cfg_addr == REG_IRQ_EN)    irq_en     <= cfg_wdata[STAT_W-1:0];
      if (cfg_we && cfg_addr == REG_IRQ_UNMSK) irq_unmask <= cfg_wdata[0];
      stat <= (stat & ~stat_clr) | stat_set;
    end
  end

  assign irq = (|(stat & irq_en)) && irq_unmask;
endmodule

// File: rtl/dma_walk_engine.sv
module dma_walk_engine
  import dma_walk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              list_sel,
  input  logic [WORD_W-1:0] src_addr,
  input  logic [WORD_W-1:0] src_size,
  input  logic [WORD_W-1:0] desc_ptr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [WORD_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  input  logic              mem_rsp_err,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last,
  output logic              busy,
  output logic              evt_done,
  output logic              evt_desc_err,
  output logic              evt_rd_err
);
  walk_state_e       state;
  logic [WORD_W-1:0] cur_desc, d_addr, d_len, d_next;
  logic [WORD_W-1:0] cur_addr, words_left, data_q;
  logic [1:0]        didx;
  logic              is_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= W_IDLE;
      cur_desc   <= '0;
      d_addr     <= '0;
      d_len      <= '0;
      d_next     <= '0;
      cur_addr   <= '0;
      words_left <= '0;
      data_q     <= '0;
      didx       <= '0;
      is_last    <= 1'b0;
    end else begin
      unique case (state)
        W_IDLE: if (start) begin
          if (list_sel) begin
            cur_desc <= desc_ptr;
            didx     <= '0;
            state    <= W_DREQ;
          end else begin
            cur_addr   <= src_addr;
            words_left <= bytes_to_words(src_size);
            is_last    <= 1'b1;
            state      <= W_CHECK;
          end
        end
        W_DREQ: if (mem_req_ready) state <= W_DWAIT;
        W_DWAIT: if (mem_rsp_valid) begin
          if (mem_rsp_err) state <= W_IDLE;
          else begin
            unique case (didx)
              2'd0: d_addr <= mem_rsp_data;
              2'd1: d_len  <= mem_rsp_data;
              2'd2: d_next <= mem_rsp_data;
              default: begin
                cur_addr   <= d_addr;
                words_left <= bytes_to_words(d_len);
                is_last    <= mem_rsp_data[FLAG_LAST_BIT];
              end
            endcase
            didx  <= didx + 2'd1;
            state <= (didx == 2'd3) ? W_CHECK : W_DREQ;
          end
        end
        W_CHECK: begin
          if (words_left != '0) state <= W_RREQ;
          else if (is_last) state <= W_FINISH;
          else begin
            cur_desc <= d_next;
            didx     <= '0;
            state    <= W_DREQ;
          end
        end
        W_RREQ: if (mem_req_ready) state <= W_RWAIT;
        W_RWAIT: if (mem_rsp_valid) begin
          if (mem_rsp_err) state <= W_IDLE;
          else begin
            data_q <= mem_rsp_data;
            state  <= W_OUT;
          end
        end
        W_OUT: if (out_ready) begin
          words_left <= words_left - 1'b1;
          cur_addr   <= cur_addr + 32'd4;
          if (words_left != 32'd1) state <= W_RREQ;
          else if (is_last) state <= W_FINISH;
          else begin
            cur_desc <= d_next;
            didx     <= '0;
            state    <= W_DREQ;
          end
        end
        default: state <= W_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (state == W_DREQ) || (state == W_RREQ);
  assign mem_req_addr  = (state == W_DREQ) ? desc_word_addr(cur_desc, didx) : cur_addr;
  assign out_valid     = (state == W_OUT);
  assign out_data      = data_q;
  assign out_last      = out_valid && is_last && (words_left == 32'd1);
  assign busy          = (state != W_IDLE);
  assign evt_done      = (state == W_FINISH);
  assign evt_desc_err  = (state == W_DWAIT) && mem_rsp_valid && mem_rsp_err;
  assign evt_rd_err    = (state == W_RWAIT) && mem_rsp_valid && mem_rsp_err;
endmodule

// File: rtl/dma_src_walker.sv
module dma_src_walker
  import dma_walk_pkg::*;
#(
  parameter int STAT_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [31:0]       mem_req_addr,
  output logic [2:0]        mem_req_attr,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  input  logic              mem_rsp_err,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [31:0]       out_data,
  output logic              out_last,
  output logic              busy,
  output logic [STAT_W-1:0] irq_status,
  output logic              irq
);
  logic              start_w, list_w;
  logic              evt_done_w, evt_desc_err_w, evt_rd_err_w;
  logic [WORD_W-1:0] src_addr_w, src_size_w, desc_ptr_w;
  logic [STAT_W-1:0] irq_en_w;
  logic              irq_unmask_w;

  dma_walk_regs #(.STAT_W(STAT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .busy(busy),
    .evt_done(evt_done_w), .evt_desc_err(evt_desc_err_w), .evt_rd_err(evt_rd_err_w),
    .start(start_w), .list_sel(list_w),
    .src_addr(src_addr_w), .src_size(src_size_w), .desc_ptr(desc_ptr_w),
    .attr(mem_req_attr), .stat(irq_status),
    .irq_en(irq_en_w), .irq_unmask(irq_unmask_w), .irq(irq)
  );

  dma_walk_engine u_engine (
    .clk(clk), .rst_n(rst_n),
    .start(start_w), .list_sel(list_w),
    .src_addr(src_addr_w), .src_size(src_size_w), .desc_ptr(desc_ptr_w),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .busy(busy),
    .evt_done(evt_done_w), .evt_desc_err(evt_desc_err_w), .evt_rd_err(evt_rd_err_w)
  );
endmodule

// File: rtl/dma_walk_checker.sv
module dma_walk_checker #(
  parameter int STAT_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [2:0]        cfg_addr,
  input logic [31:0]       cfg_wdata,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [31:0]       mem_req_addr,
  input logic              out_valid,
  input logic              out_ready,
  input logic [31:0]       out_data,
  input logic              busy,
  input logic              evt_rd_err,
  input logic              evt_desc_err,
  input logic [STAT_W-1:0] irq_status,
  input logic [STAT_W-1:0] irq_en,
  input logic              irq_unmask,
  input logic              irq
);
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  assert_no_read_while_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !mem_req_valid);

  assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_rd_err_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rd_err |=> !busy && irq_status[4]);

  assert_desc_err_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_desc_err |=> !busy && irq_status[3]);

  assert_no_run_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && cfg_we && cfg_addr == 3'd0 && !cfg_wdata[31] |=> !busy);

  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_unmask && (irq_status & irq_en) != '0);
endmodule

bind dma_src_walker dma_walk_checker #(.STAT_W(STAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .busy(busy), .evt_rd_err(evt_rd_err_w), .evt_desc_err(evt_desc_err_w),
  .irq_status(irq_status), .irq_en(irq_en_w), .irq_unmask(irq_unmask_w), .irq(irq)
);

// File: tb/dma_src_walker_bench.sv
`timescale 1ns/1ps
module dma_src_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        mem_req_valid, mem_req_ready;
  logic [31:0] mem_req_addr;
  logic [2:0]  mem_req_attr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        mem_rsp_err = 1'b0;
  logic        out_valid, out_last;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic        busy, irq;
  logic [8:0]  irq_status;

  always #5 clk = ~clk;

  dma_src_walker u_dma_src_walker (.*);

  logic [31:0] mem [256];
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic [2:0]  exp_attr = 3'd0;
  logic        stall_on = 1'b0;
  logic        cyc = 1'b0;
  int          data_reads = 0, attr_bad = 0;
  logic [31:0] rx [64];
  int          rx_cnt = 0, last_cnt = 0, last_pos = -1;
  int          tests = 0, fails = 0;
  bit          finished = 0;

  assign mem_req_ready = stall_on ? cyc : 1'b1;

  always @(posedge clk) begin
    cyc <= ~cyc;
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= mem[mem_req_addr[9:2]];
      mem_rsp_err   <= (mem_req_addr == err_addr);
      if (mem_req_addr < 32'h200) data_reads <= data_reads + 1;
      if (mem_req_attr != exp_attr) attr_bad <= attr_bad + 1;
    end
    if (out_valid && out_ready) begin
      rx[rx_cnt[5:0]] <= out_data;
      if (out_last) begin
        last_cnt <= last_cnt + 1;
        last_pos <= rx_cnt;
      end
      rx_cnt <= rx_cnt + 1;
    end
  end

  function automatic logic [31:0] pattern(input logic [31:0] byte_addr);
    return 32'hC0DE_0000 | (byte_addr >> 2);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_idle();
    int g = 0;
    @(negedge clk);
    while (busy && g < 3000) begin @(negedge clk); g++; end
  endtask

  task automatic clear_rx();
    @(negedge clk);
    rx_cnt = 0; last_cnt = 0; last_pos = -1; data_reads = 0; attr_bad = 0;
  endtask

  task automatic put_desc(input int base, input logic [31:0] a, input logic [31:0] l,
                          input logic [31:0] n, input logic [31:0] f);
    mem[base/4] = a; mem[base/4+1] = l; mem[base/4+2] = n; mem[base/4+3] = f;
  endtask

  // {source byte address, byte size}
  localparam logic [63:0] VECS [6] = '{
    {32'h010, 32'd4}, {32'h020, 32'd8}, {32'h040, 32'd6},
    {32'h080, 32'd1}, {32'h100, 32'd40}, {32'h0F0, 32'd0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = pattern(32'(i * 4));
    repeat (3) @(negedge clk);
    chk(!busy && !out_valid && !mem_req_valid, "R5 reset idle", {29'b0, busy, out_valid, mem_req_valid}, 0);
    chk(irq_status == 0 && !irq, "R10 reset status", {22'b0, irq, irq_status}, 0);
    rst_n = 1'b1;

    // Table of direct transfers
    for (int v = 0; v < 6; v++) begin
      logic [31:0] a, s;
      int n;
      a = VECS[v][63:32]; s = VECS[v][31:0];
      n = int'((s + 3) / 4);
      clear_rx();
      wr(3'd4, 32'h1FF);
      wr(3'd1, a);
      wr(3'd2, s);
      wr(3'd0, 32'h8000_0000);
      wait_idle();
      chk(rx_cnt == n, "R1 direct word count", rx_cnt, n);
      for (int k = 0; k < n; k++)
        chk(rx[k] == pattern(a + 32'(4 * k)), "R1 direct data", rx[k], pattern(a + 32'(4 * k)));
      chk(irq_status[0], "R7 done after direct", irq_status, 1);
      if (n > 0) chk(last_cnt == 1 && last_pos == n - 1, "R7 last marker", last_pos, n - 1);
      else chk(last_cnt == 0, "R7 no last for empty", last_cnt, 0);
    end

    // Chain: D0 8B, D1 0B, D2 12B terminate, D3 never reached
    put_desc(32'h200, 32'h000, 32'd8,  32'h210, 32'h0);
    put_desc(32'h210, 32'h050, 32'd0,  32'h220, 32'h0);
    put_desc(32'h220, 32'h060, 32'd12, 32'h230, 32'h8000_0000);
    put_desc(32'h230, 32'h070, 32'd4,  32'h000, 32'h8000_0000);
    clear_rx();
    exp_attr = 3'b101;
    wr(3'd4, 32'h1FF);
    wr(3'd3, 32'h200);
    wr(3'd0, 32'hD200_0000);
    wait_idle();
    chk(rx_cnt == 5, "R2 R3 chain word count", rx_cnt, 5);
    chk(rx[0] == pattern(32'h000) && rx[1] == pattern(32'h004), "R2 first descriptor data", rx[1], pattern(32'h004));
    chk(rx[2] == pattern(32'h060) && rx[4] == pattern(32'h068), "R3 follows next pointer", rx[4], pattern(32'h068));
    chk(data_reads == 5, "R4 zero length issues no reads", data_reads, 5);
    chk(attr_bad == 0, "R6 attribute on requests", attr_bad, 0);
    chk(irq_status == 9'h001 && last_pos == 4, "R7 chain done", irq_status, 1);

    // Interrupt gating and clear
    wr(3'd5, 32'h1);
    wr(3'd6, 32'h0);
    chk(!irq, "R10 masked", irq, 0);
    wr(3'd6, 32'h1);
    chk(irq, "R10 unmasked", irq, 1);
    wr(3'd4, 32'h1);
    chk(irq_status == 0 && !irq, "R10 write one clears", irq_status, 0);

    // Data read error
    exp_attr = 3'b000;
    clear_rx();
    err_addr = 32'h064;
    wr(3'd5, 32'h10);
    wr(3'd0, 32'h8200_0000);
    wait_idle();
    chk(irq_status == 9'h010, "R8 data error status", irq_status, 9'h010);
    chk(rx_cnt == 3 && irq, "R8 abort after error", rx_cnt, 3);
    wr(3'd4, 32'h1FF);

    // Descriptor read error
    clear_rx();
    err_addr = 32'h214;
    wr(3'd0, 32'h8200_0000);
    wait_idle();
    chk(irq_status == 9'h008, "R9 descriptor error status", irq_status, 9'h008);
    chk(rx_cnt == 2, "R9 abort words", rx_cnt, 2);
    err_addr = 32'hFFFF_FFFF;
    wr(3'd4, 32'h1FF);

    // Mode write while busy is ignored; stalled handshake
    clear_rx();
    stall_on = 1'b1;
    out_ready = 1'b0;
    wr(3'd1, 32'h010);
    wr(3'd2, 32'd16);
    wr(3'd0, 32'h8000_0000);
    repeat (6) @(negedge clk);
    chk(busy, "R5 busy during stall", busy, 1);
    wr(3'd1, 32'h100);
    wr(3'd0, 32'h8200_0000);
    out_ready = 1'b1;
    wait_idle();
    repeat (20) @(negedge clk);
    stall_on = 1'b0;
    chk(!busy && rx_cnt == 4, "R5 write while busy ignored", rx_cnt, 4);
    chk(rx[0] == pattern(32'h010) && rx[3] == pattern(32'h01C), "R11 data under stall", rx[3], pattern(32'h01C));

    // Mode write without run bit
    clear_rx();
    wr(3'd0, 32'h0200_0000);
    repeat (10) @(negedge clk);
    chk(!busy && data_reads == 0 && rx_cnt == 0, "R5 no run bit no start", data_reads, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule